// File: doc/BRIEF.md
# LPC Bus Transaction Monitor

A passive observer for a low-pin-count host bus that uses four multiplexed address/control/data lines and an active-low frame strobe. On every rising bus clock it samples the strobe and the nibble lines and follows each target cycle through its fields. The fields are the start code, the cycle kind and direction, the address, a turn-around, the sync handshake, the data byte and a closing turn-around. The monitor has no output toward the bus and never drives it.

When a target cycle completes, the monitor raises a one-clock record strobe. It presents the effective start code, the cycle-kind nibble, the assembled address and the data byte at the same time. Protocol problems are reported as one-clock warning pulses, each with its own bit. Stop codes and cycles the monitor does not follow (firmware memory, bus-master grants, DMA) produce an abort or unsupported pulse, and the monitor then waits for the next frame. The monitor is meant for bring-up logic, trace capture and protocol checkers that sit beside a host or peripheral.

Top module: `lpcmon_top`

## Requirements
- R1: A synchronous active-high `rst` returns the monitor to idle. While in reset and on the clock after it, `rec_valid`, `abort_seen`, `unsupported_seen` and `warn` are all zero. Nibbles seen with the strobe high after reset create no events.
- R2: A cycle opens on a clock where `frame_n` is low while idle. Every clock with `frame_n` low carries a start nibble, and the nibble on the last such clock is the effective start code. Code 0000 opens a target cycle.
- R3: If the start nibble differs from the one on the previous clock while `frame_n` stays low, `warn[0]` pulses one clock after that sample.
- R4: If the effective start code is 1111, `abort_seen` pulses and no record follows. Any other code except 0000 (for example 1101, 1110, 0010, 0011) pulses `unsupported_seen`. After either pulse, nibbles are ignored until `frame_n` falls again.
- R5: On the first clock with `frame_n` high, the cycle-kind nibble is taken. The values are 0000 for an I/O read, 0010 for an I/O write, 0100 for a memory read and 0110 for a memory write. I/O cycles take 4 address nibbles and memory cycles take 8, most significant nibble first. For an I/O cycle, `rec_addr` bits above 15 are zero.
- R6: A cycle-kind nibble with bit 0 set, or with the pattern 11x0, pulses `warn[1]` and the cycle is dropped. Nibbles 1000 and 1010 pulse `unsupported_seen` and the cycle is dropped.
- R7: Each of the two turn-arounds lasts 2 clocks, and 1111 is expected on both clocks. On any other value, `warn[2]` pulses and `warn_tar_pos` shows the position: bit 1 is 0 for the turn-around after the address and 1 for the one after the data, and bit 0 is the clock index (0 or 1).
- R8: During sync, 0000 moves on to the data field, while 0101 and 0110 keep waiting. Any other value except 1010, including 1001, pulses `warn[3]` and the monitor keeps waiting.
- R9: A sync of 1010 ends the cycle at once with `rec_valid` and `rec_err` both high, the address seen so far and `rec_data` equal to 0.
- R10: The data byte takes 2 clocks, low nibble first, and is followed by the closing turn-around. `rec_valid` pulses for one clock after the second clock of that turn-around, with `rec_err` low.
- R11: If `frame_n` is low on a clock in any field after the cycle-kind nibble, `abort_seen` pulses. That nibble is then taken as a new start nibble and the monitor continues in the start field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Observed frame strobe, active low |
| lad | input | 4 | Observed address/control/data nibble |
| rec_valid | output | 1 | One-clock strobe: a cycle record is presented |
| rec_err | output | 1 | Record ended with an error sync |
| rec_start | output | 4 | Effective start code of the record |
| rec_ctype | output | 4 | Cycle-kind nibble of the record |
| rec_addr | output | 4*MEM_NIBS | Assembled address, zero-extended for I/O |
| rec_data | output | 8 | Data byte of the record |
| abort_seen | output | 1 | One-clock pulse: stop code or frame restart |
| unsupported_seen | output | 1 | One-clock pulse: cycle kind not followed |
| warn | output | 4 | Warning pulses: [0] start change, [1] bad kind, [2] turn-around, [3] sync value |
| warn_tar_pos | output | 2 | Position of the last turn-around warning |

## Verification
The bench builds the monitor with its default parameters: 4 address nibbles for I/O and 8 for memory. This puts both address widths, and the zero upper half of an I/O address, within reach in the same run. With these values each of the four cycle kinds, the wait and error syncs and the mid-cycle restart can be driven in a few dozen clocks each. This keeps the full set of field orders and warning positions inside a short run.

// File: rtl/lpcmon_pkg.sv
`timescale 1ns/1ps
package lpcmon_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_ADDR,
        S_TAR1,
        S_SYNC,
        S_DATA,
        S_TAR2
    } mon_state_e;

    typedef enum logic [1:0] {
        CK_OK,
        CK_BAD,
        CK_UNSUP
    } kind_class_e;

    typedef struct packed {
        logic clr;
        logic addr_en;
        logic lo_en;
        logic hi_en;
    } asm_ctrl_t;

    localparam logic [3:0] START_TARGET = 4'b0000;
    localparam logic [3:0] START_STOP   = 4'b1111;
    localparam logic [3:0] TAR_IDLE     = 4'b1111;
    localparam logic [3:0] SYNC_READY   = 4'b0000;
    localparam logic [3:0] SYNC_SHORT   = 4'b0101;
    localparam logic [3:0] SYNC_LONG    = 4'b0110;
    localparam logic [3:0] SYNC_FAULT   = 4'b1010;

    localparam int WARN_START = 0;
    localparam int WARN_KIND  = 1;
    localparam int WARN_TAR   = 2;
    localparam int WARN_SYNC  = 3;
    localparam int N_WARN     = 4;

    function automatic kind_class_e classify_kind(input logic [3:0] n);
        if (n[0] || n[3:2] == 2'b11) return CK_BAD;
        if (n[3])                    return CK_UNSUP;
        return CK_OK;
    endfunction

    function automatic logic kind_is_io(input logic [3:0] n);
        return n[3:2] == 2'b00;
    endfunction

endpackage

// File: rtl/lpcmon_asm.sv
`timescale 1ns/1ps
module lpcmon_asm
    import lpcmon_pkg::*;
#(
    parameter int MEM_NIBS = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [3:0]              lad,
    input  asm_ctrl_t               ctrl,
    output logic [4*MEM_NIBS-1:0]   addr_o,
    output logic [7:0]              data_o
);
    localparam int ADDR_W = 4 * MEM_NIBS;
    localparam int LANES  = 2;

    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [LANES-1:0]  lane_en;

    assign lane_en = {ctrl.hi_en, ctrl.lo_en};

    // Address nibbles enter at the bottom, so the first one ends up highest.
    always_ff @(posedge clk) begin
        if (rst || ctrl.clr) begin
            addr_q <= '0;
        end else if (ctrl.addr_en) begin
            addr_q <= {addr_q[ADDR_W-5:0], lad};
        end
    end

    // Data lanes: lane 0 is the low nibble, written first.
    always_ff @(posedge clk) begin
        if (rst || ctrl.clr) begin
            data_q <= '0;
        end else begin
            for (int g = 0; g < LANES; g++) begin
                if (lane_en[g]) data_q[g*4 +: 4] <= lad;
            end
        end
    end

    p_lanes_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.lo_en && ctrl.hi_en))
        else $error("p_lanes_exclusive_r10");

    p_low_lane_first_r10: assert property (@(posedge clk) disable iff (rst)
        ctrl.lo_en |=> (data_o[3:0] == $past(lad)))
        else $error("p_low_lane_first_r10");

    assign addr_o = addr_q;
    assign data_o = data_q;

endmodule

// File: rtl/lpcmon_seq.sv
`timescale 1ns/1ps
module lpcmon_seq
    import lpcmon_pkg::*;
#(
    parameter int IO_NIBS  = 4,
    parameter int MEM_NIBS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic [3:0]        lad,
    output asm_ctrl_t         ctrl,
    output logic              done_o,
    output logic              err_o,
    output logic [3:0]        start_o,
    output logic [3:0]        kind_o,
    output logic              abort_o,
    output logic              unsup_o,
    output logic [N_WARN-1:0] warn_o,
    output logic [1:0]        tar_pos_o
);
    localparam int CNT_W = $clog2(MEM_NIBS + 1);

    mon_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [3:0]        start_q, start_d;
    logic [3:0]        kind_q, kind_d;
    logic [1:0]        tpos_q, tpos_d;
    logic              abort_q, abort_d;
    logic              unsup_q, unsup_d;
    logic              done_q, done_d;
    logic              err_q, err_d;
    logic [N_WARN-1:0] warn_q, warn_d;
    logic              in_body;

    assign in_body = (state_q != S_IDLE) && (state_q != S_START);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        start_d = start_q;
        kind_d  = kind_q;
        tpos_d  = tpos_q;
        abort_d = 1'b0;
        unsup_d = 1'b0;
        done_d  = 1'b0;
        err_d   = 1'b0;
        warn_d  = '0;
        ctrl    = '0;

        if (in_body && !frame_n) begin
            abort_d = 1'b1;
            start_d = lad;
            state_d = S_START;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (!frame_n) begin
                        start_d = lad;
                        state_d = S_START;
                    end
                end
                S_START: begin
                    if (!frame_n) begin
                        if (lad != start_q) warn_d[WARN_START] = 1'b1;
                        start_d = lad;
                    end else if (start_q == START_STOP) begin
                        abort_d = 1'b1;
                        state_d = S_IDLE;
                    end else if (start_q != START_TARGET) begin
                        unsup_d = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        unique case (classify_kind(lad))
                            CK_OK: begin
                                kind_d   = lad;
                                ctrl.clr = 1'b1;
                                cnt_d    = kind_is_io(lad) ? CNT_W'(IO_NIBS - 1)
                                                           : CNT_W'(MEM_NIBS - 1);
                                state_d  = S_ADDR;
                            end
                            CK_BAD: begin
                                warn_d[WARN_KIND] = 1'b1;
                                state_d = S_IDLE;
                            end
                            default: begin
                                unsup_d = 1'b1;
                                state_d = S_IDLE;
                            end
                        endcase
                    end
                end
                S_ADDR: begin
                    ctrl.addr_en = 1'b1;
                    if (cnt_q == '0) begin
                        state_d = S_TAR1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                S_TAR1, S_TAR2: begin
                    if (lad != TAR_IDLE) begin
                        warn_d[WARN_TAR] = 1'b1;
                        tpos_d = {state_q == S_TAR2, cnt_q[0]};
                    end
                    if (cnt_q[0]) begin
                        cnt_d = '0;
                        if (state_q == S_TAR1) begin
                            state_d = S_SYNC;
                        end else begin
                            done_d  = 1'b1;
                            state_d = S_IDLE;
                        end
                    end else begin
                        cnt_d = CNT_W'(1);
                    end
                end
                S_SYNC: begin
                    if (lad == SYNC_READY) begin
                        cnt_d   = '0;
                        state_d = S_DATA;
                    end else if (lad == SYNC_FAULT) begin
                        done_d  = 1'b1;
                        err_d   = 1'b1;
                        state_d = S_IDLE;
                    end else if (lad != SYNC_SHORT && lad != SYNC_LONG) begin
                        warn_d[WARN_SYNC] = 1'b1;
                    end
                end
                S_DATA: begin
                    if (cnt_q == '0) begin
                        ctrl.lo_en = 1'b1;
                        cnt_d = CNT_W'(1);
                    end else begin
                        ctrl.hi_en = 1'b1;
                        cnt_d = '0;
                        state_d = S_TAR2;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            start_q <= '0;
            kind_q  <= '0;
            tpos_q  <= '0;
            abort_q <= 1'b0;
            unsup_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            warn_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            start_q <= start_d;
            kind_q  <= kind_d;
            tpos_q  <= tpos_d;
            abort_q <= abort_d;
            unsup_q <= unsup_d;
            done_q  <= done_d;
            err_q   <= err_d;
            warn_q  <= warn_d;
        end
    end

    p_frame_restart_r11: assert property (@(posedge clk) disable iff (rst)
        (in_body && !frame_n) |=> (abort_q && state_q == S_START))
        else $error("p_frame_restart_r11");

    p_stop_code_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_START && frame_n && start_q == START_STOP)
            |=> (abort_q && state_q == S_IDLE && !done_q))
        else $error("p_stop_code_r4");

    p_sync_wait_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_SYNC && frame_n && (lad == SYNC_SHORT || lad == SYNC_LONG))
            |=> (state_q == S_SYNC && !done_q))
        else $error("p_sync_wait_r8");

    p_sync_fault_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_SYNC && frame_n && lad == SYNC_FAULT) |=> (done_q && err_q))
        else $error("p_sync_fault_r9");

    p_single_record_r10: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q)
        else $error("p_single_record_r10");

    p_no_abort_with_record_r11: assert property (@(posedge clk) disable iff (rst)
        !(abort_q && done_q))
        else $error("p_no_abort_with_record_r11");

    assign done_o    = done_q;
    assign err_o     = err_q;
    assign start_o   = start_q;
    assign kind_o    = kind_q;
    assign abort_o   = abort_q;
    assign unsup_o   = unsup_q;
    assign warn_o    = warn_q;
    assign tar_pos_o = tpos_q;

endmodule

// File: rtl/lpcmon_top.sv
`timescale 1ns/1ps
module lpcmon_top
    import lpcmon_pkg::*;
#(
    parameter int IO_NIBS  = 4,
    parameter int MEM_NIBS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_n,
    input  logic [3:0]            lad,
    output logic                  rec_valid,
    output logic                  rec_err,
    output logic [3:0]            rec_start,
    output logic [3:0]            rec_ctype,
    output logic [4*MEM_NIBS-1:0] rec_addr,
    output logic [7:0]            rec_data,
    output logic                  abort_seen,
    output logic                  unsupported_seen,
    output logic [3:0]            warn,
    output logic [1:0]            warn_tar_pos
);
    localparam int ADDR_W    = 4 * MEM_NIBS;
    localparam int IO_ADDR_W = 4 * IO_NIBS;

    asm_ctrl_t ctrl;

    lpcmon_seq #(
        .IO_NIBS  (IO_NIBS),
        .MEM_NIBS (MEM_NIBS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .frame_n   (frame_n),
        .lad       (lad),
        .ctrl      (ctrl),
        .done_o    (rec_valid),
        .err_o     (rec_err),
        .start_o   (rec_start),
        .kind_o    (rec_ctype),
        .abort_o   (abort_seen),
        .unsup_o   (unsupported_seen),
        .warn_o    (warn),
        .tar_pos_o (warn_tar_pos)
    );

    lpcmon_asm #(
        .MEM_NIBS (MEM_NIBS)
    ) u_asm (
        .clk    (clk),
        .rst    (rst),
        .lad    (lad),
        .ctrl   (ctrl),
        .addr_o (rec_addr),
        .data_o (rec_data)
    );

    generate
        if (IO_ADDR_W < ADDR_W) begin : g_io_width_chk
            p_io_addr_narrow_r5: assert property (@(posedge clk) disable iff (rst)
                (rec_valid && kind_is_io(rec_ctype))
                    |-> (rec_addr[ADDR_W-1:IO_ADDR_W] == '0))
                else $error("p_io_addr_narrow_r5");
        end
    endgenerate

    p_record_is_target_r2: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_start == START_TARGET))
        else $error("p_record_is_target_r2");

endmodule

// File: tb/tb_lpcmon_top.sv
`timescale 1ns/1ps
module tb_lpcmon_top;

    localparam int K_WARN  = 0;
    localparam int K_ABORT = 1;
    localparam int K_UNSUP = 2;
    localparam int K_REC   = 3;

    typedef struct {
        int          kind;
        logic [3:0]  a;
        logic [3:0]  b;
        logic [31:0] addr;
        logic [7:0]  data;
        logic        err;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic [3:0]  lad = 4'hF;
    logic        rec_valid, rec_err, abort_seen, unsupported_seen;
    logic [3:0]  rec_start, rec_ctype, warn;
    logic [31:0] rec_addr;
    logic [7:0]  rec_data;
    logic [1:0]  warn_tar_pos;

    int   checks = 0;
    int   errors = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    lpcmon_top dut (
        .clk              (clk),
        .rst              (rst),
        .frame_n          (frame_n),
        .lad              (lad),
        .rec_valid        (rec_valid),
        .rec_err          (rec_err),
        .rec_start        (rec_start),
        .rec_ctype        (rec_ctype),
        .rec_addr         (rec_addr),
        .rec_data         (rec_data),
        .abort_seen       (abort_seen),
        .unsupported_seen (unsupported_seen),
        .warn             (warn),
        .warn_tar_pos     (warn_tar_pos)
    );

    // ---------------- expectation helpers ----------------
    task automatic push(input int k, input logic [3:0] a, input logic [3:0] b,
                        input logic [31:0] ad, input logic [7:0] d, input logic e,
                        input string req);
        exp_t x;
        x.kind = k; x.a = a; x.b = b; x.addr = ad; x.data = d; x.err = e; x.req = req;
        q.push_back(x);
    endtask

    task automatic exp_warn(input int w, input int pos, input string req);
        push(K_WARN, 4'(w), 4'(pos), 32'h0, 8'h0, 1'b0, req);
    endtask

    task automatic exp_rec(input logic [3:0] ct, input logic [31:0] ad,
                           input logic [7:0] d, input logic e, input string req);
        push(K_REC, 4'h0, ct, ad, d, e, req);
    endtask

    // ---------------- monitor / scoreboard ----------------
    task automatic observe(input int k, input logic [3:0] a, input logic [3:0] b,
                           input logic [31:0] ad, input logic [7:0] d, input logic e);
        exp_t x;
        bit   bad;
        checks++;
        if (q.size() == 0) begin
            errors++;
            $display("FAIL unexpected event: got kind %0d a %h b %h addr %h data %h err %b, expected none",
                     k, a, b, ad, d, e);
            return;
        end
        x = q.pop_front();
        bad = (x.kind != k) || (x.a != a);
        if (k == K_WARN && a == 4'd2 && x.b[1:0] != b[1:0]) bad = 1'b1;
        if (k == K_REC && (x.b != b || x.addr != ad || x.data != d || x.err != e)) bad = 1'b1;
        if (bad) begin
            errors++;
            $display("FAIL %s: got kind %0d a %h b %h addr %h data %h err %b, expected kind %0d a %h b %h addr %h data %h err %b",
                     x.req, k, a, b, ad, d, e, x.kind, x.a, x.b, x.addr, x.data, x.err);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            for (int w = 0; w < 4; w++)
                if (warn[w]) observe(K_WARN, 4'(w), {2'b00, warn_tar_pos}, 32'h0, 8'h0, 1'b0);
            if (abort_seen)       observe(K_ABORT, 4'h0, 4'h0, 32'h0, 8'h0, 1'b0);
            if (unsupported_seen) observe(K_UNSUP, 4'h0, 4'h0, 32'h0, 8'h0, 1'b0);
            if (rec_valid)        observe(K_REC, rec_start, rec_ctype, rec_addr, rec_data, rec_err);
        end
    end

    // ---------------- driver ----------------
    task automatic nib(input logic f, input logic [3:0] v);
        @(negedge clk);
        frame_n = f;
        lad     = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) nib(1'b1, 4'hF);
    endtask

    task automatic check_quiet(input string req);
        checks++;
        if (rec_valid || abort_seen || unsupported_seen || warn != 4'h0) begin
            errors++;
            $display("FAIL %s: got valid %b abort %b unsup %b warn %h, expected all zero",
                     req, rec_valid, abort_seen, unsupported_seen, warn);
        end
    endtask

    // Everything after the start field; bad_tar 0..3 picks one bad turn-around clock.
    task automatic body(input logic [3:0] ct, input logic [31:0] ad, input logic [7:0] d,
                        input int nwait, input int bad_tar, input bit rsv_sync,
                        input bit sync_fault, input string req);
        int          nn;
        logic [31:0] ea;
        nn = (ct[3:2] == 2'b00) ? 4 : 8;
        ea = (nn == 4) ? {16'h0, ad[15:0]} : ad;
        nib(1'b1, ct);
        for (int i = nn - 1; i >= 0; i--) nib(1'b1, ad[i*4 +: 4]);
        for (int t = 0; t < 2; t++) begin
            if (bad_tar == t) exp_warn(2, t, "R7");
            nib(1'b1, (bad_tar == t) ? 4'b0111 : 4'hF);
        end
        for (int k = 0; k < nwait; k++) nib(1'b1, k[0] ? 4'b0110 : 4'b0101);
        if (rsv_sync) begin
            exp_warn(3, 0, "R8");
            nib(1'b1, 4'b0011);
            exp_warn(3, 0, "R8");
            nib(1'b1, 4'b1001);
        end
        if (sync_fault) begin
            exp_rec(ct, ea, 8'h00, 1'b1, "R9");
            nib(1'b1, 4'b1010);
            return;
        end
        nib(1'b1, 4'b0000);
        nib(1'b1, d[3:0]);
        nib(1'b1, d[7:4]);
        for (int t = 2; t < 4; t++) begin
            if (bad_tar == t) exp_warn(2, t, "R7");
            if (t == 3) exp_rec(ct, ea, d, 1'b0, req);
            nib(1'b1, (bad_tar == t) ? 4'b0111 : 4'hF);
        end
    endtask

    task automatic cycle(input logic [3:0] ct, input logic [31:0] ad, input logic [7:0] d,
                         input int nwait, input string req);
        nib(1'b0, 4'h0);
        body(ct, ad, d, nwait, -1, 1'b0, 1'b0, req);
        idle(2);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got no end of test, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        check_quiet("R1 reset state");
        rst = 1'b0;
        idle(2);

        // R5/R10/R2: memory read and I/O write
        cycle(4'b0100, 32'h1234ABCD, 8'h5A, 0, "R10 mem read");
        cycle(4'b0000, 32'h0000BEEF, 8'h3C, 0, "R5 io read");
        cycle(4'b0010, 32'hFFFF1357, 8'hC3, 3, "R8 io write with waits");
        cycle(4'b0110, 32'h80000001, 8'hFF, 1, "R5 mem write");

        // R2: start held for several clocks
        nib(1'b0, 4'h0); nib(1'b0, 4'h0); nib(1'b0, 4'h0);
        body(4'b0110, 32'hCAFE0042, 8'h81, 0, -1, 1'b0, 1'b0, "R2 long start");
        idle(2);

        // R3: start nibble changes, last one (0000) wins
        nib(1'b0, 4'hF);
        exp_warn(0, 0, "R3");
        nib(1'b0, 4'h0);
        body(4'b0100, 32'h00C0FFEE, 8'h24, 0, -1, 1'b0, 1'b0, "R3 last start wins");
        idle(2);

        // R4: stop code
        nib(1'b0, 4'hF);
        push(K_ABORT, 4'h0, 4'h0, 32'h0, 8'h0, 1'b0, "R4 stop");
        nib(1'b1, 4'hF);
        idle(2);

        // R4: firmware and grant codes, trailing nibbles ignored
        nib(1'b0, 4'b1101);
        push(K_UNSUP, 4'h0, 4'h0, 32'h0, 8'h0, 1'b0, "R4 firmware read");
        nib(1'b1, 4'b0100);
        nib(1'b1, 4'b0000); nib(1'b1, 4'b1010); nib(1'b1, 4'b0011);
        nib(1'b0, 4'b0010);
        push(K_UNSUP, 4'h0, 4'h0, 32'h0, 8'h0, 1'b0, "R4 grant");
        nib(1'b1, 4'b0000);
        idle(3);

        // R6: bad and unsupported cycle kinds
        nib(1'b0, 4'h0);
        exp_warn(1, 0, "R6 kind 1100");
        nib(1'b1, 4'b1100);
        nib(1'b1, 4'h1); nib(1'b1, 4'h0);
        nib(1'b0, 4'h0);
        exp_warn(1, 0, "R6 kind 0001");
        nib(1'b1, 4'b0001);
        idle(2);
        nib(1'b0, 4'h0);
        push(K_UNSUP, 4'h0, 4'h0, 32'h0, 8'h0, 1'b0, "R6 kind 1000");
        nib(1'b1, 4'b1000);
        idle(3);

        // R7: turn-around warnings at each position
        for (int t = 0; t < 4; t++) begin
            nib(1'b0, 4'h0);
            body(4'b0100, 32'h10203040 + 32'(t), 8'h11 * 8'(t + 1), 0, t, 1'b0, 1'b0, "R7 cycle");
            idle(2);
        end

        // R8: reserved sync values keep waiting
        nib(1'b0, 4'h0);
        body(4'b0000, 32'h00002468, 8'h9E, 1, -1, 1'b1, 1'b0, "R8 reserved sync");
        idle(2);

        // R9: error sync
        nib(1'b0, 4'h0);
        body(4'b0110, 32'hDEADBEEF, 8'h77, 0, -1, 1'b0, 1'b1, "R9");
        idle(3);

        // R11: frame restart in the middle of the address
        nib(1'b0, 4'h0);
        nib(1'b1, 4'b0100);
        nib(1'b1, 4'h1); nib(1'b1, 4'h2);
        push(K_ABORT, 4'h0, 4'h0, 32'h0, 8'h0, 1'b0, "R11 restart");
        nib(1'b0, 4'h0);
        body(4'b0010, 32'h0000A5A5, 8'h5C, 0, -1, 1'b0, 1'b0, "R11 new cycle");
        idle(2);

        // R1: reset mid-cycle, later nibbles create nothing
        nib(1'b0, 4'h0);
        nib(1'b1, 4'b0110);
        nib(1'b1, 4'h3);
        @(negedge clk);
        rst = 1'b1; frame_n = 1'b1; lad = 4'hF;
        @(negedge clk);
        check_quiet("R1 reset mid-cycle");
        rst = 1'b0;
        nib(1'b1, 4'h0); nib(1'b1, 4'h0); nib(1'b1, 4'hF);
        cycle(4'b0100, 32'h0F0F0F0F, 8'hE1, 0, "R1 after reset");

        idle(4);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL pending events: got %0d still expected, expected 0", q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule